// File: doc/BRIEF.md
# Rectify-and-Leak Envelope Follower

This block tracks the amplitude envelope of a signed sample stream at very low cost. It does in logic what a diode and an RC network do in an analog detector. Each accepted sample is full-wave rectified and summed into a leaky integrator. On every accepted sample, the integrator also drops a power-of-two fraction of its own value.

The rectifier is not a separate stage. The sign bit of the sample chooses whether the sample is added to the state or subtracted from it. The parameter `SHIFT` sets the leak fraction to 1/2^SHIFT, so it sets the cutoff relative to the sample rate. The default is 6, a leak of 1/64.

The detector only gives a clean envelope when the carrier lies well above the modulation bandwidth. The reported envelope is the state shifted right by `SHIFT`, which puts it back in input-scale units.

Top module: `env_follower`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state is cleared to zero, and `env_out` reads 0 after that edge.
- R2: At a rising edge where `smp_vld` is low, the state keeps its value whatever `smp_in` holds, so `env_out` does not change.
- R3: At a rising edge where `smp_vld` is high, the state A becomes A - floor(A / 2^SHIFT) + |x|. Here x is `smp_in`, read as two's complement, and the sign bit is bit IN_W-1. A negative x is subtracted and a non-negative x is added.
- R4: The most negative input code, -2^(IN_W-1), contributes +2^(IN_W-1) to the state, with no wraparound.
- R5: The state is IN_W+SHIFT bits wide and never overflows, even when the input is held at the largest magnitude.
- R6: `env_out` equals the state shifted right by SHIFT bits. It is unsigned and IN_W bits wide, and it shows the new value right after the edge that accepted the sample.
- R7: With zero samples accepted, the state never increases.
- R8: When a constant magnitude M is applied, with either sign, `env_out` settles at exactly M. Sample sequences of opposite sign give identical envelopes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample-valid strobe |
| smp_in | input | IN_W | Signed input sample |
| env_out | output | IN_W | Unsigned envelope value |

## Verification
The assertions check on every cycle:
- the state holds when no sample is accepted;
- the reset clears the state;
- the rectify-accumulate never carries out of its width;
- the state does not grow on zero samples;
- the most negative code adds its full magnitude whenever the leak is zero.

Only the bench's scenarios can show the exact update formula across long runs, and that the settle point equals the applied magnitude. The same holds for sign symmetry, and for the envelope's response to amplitude steps and to a modulated carrier. The bench checks all of these against an independent arithmetic model.

// File: rtl/env_follow_pkg.sv
package env_follow_pkg;

   // Width of the integrator state for a given input width and leak shift.
   function automatic int unsigned acc_width(input int unsigned in_w, input int unsigned shift);
      return in_w + shift;
   endfunction

   // Magnitude of the most negative input code.
   function automatic longint unsigned min_code_mag(input int unsigned in_w);
      return longint'(1) << (in_w - 1);
   endfunction

endpackage

// File: rtl/env_leak.sv
// Leak stage: removes state / 2^SHIFT (floor) from the current state.
module env_leak #(
   parameter int unsigned ACC_W = 22,
   parameter int unsigned SHIFT = 6
) (
   input  logic [ACC_W-1:0] state_q,
   output logic [ACC_W-1:0] leaked
);

   logic [ACC_W-1:0] frac;

   always_comb begin
      frac   = state_q >> SHIFT;
      leaked = state_q - frac;
   end

endmodule

// File: rtl/env_rect_accum.sv
// Folded rectifier: the sample's sign bit picks add or subtract.
module env_rect_accum #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned ACC_W = 22
) (
   input  logic [ACC_W-1:0]        base,
   input  logic signed [IN_W-1:0]  sample,
   output logic [ACC_W-1:0]        sum,
   output logic                    carry
);

   localparam int unsigned EXT_W = ACC_W + 1;

   logic [EXT_W-1:0] base_ext;
   logic [EXT_W-1:0] smp_ext;
   logic [EXT_W-1:0] res;
   logic             neg;

   always_comb begin
      neg      = sample[IN_W-1];
      base_ext = {1'b0, base};
      smp_ext  = EXT_W'(signed'(sample));   // sign extension keeps MIN exact (R4)
      if (neg) res = base_ext - smp_ext;
      else     res = base_ext + smp_ext;
      sum   = res[ACC_W-1:0];
      carry = res[EXT_W-1];
   end

endmodule

// File: rtl/env_state_reg.sv
// Integrator state register with the per-cycle checks.
module env_state_reg #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned SHIFT = 6,
   parameter int unsigned ACC_W = 22
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load,
   input  logic [ACC_W-1:0]       nxt,
   input  logic                   nxt_carry,
   input  logic signed [IN_W-1:0] sample,
   output logic [ACC_W-1:0]       state_q
);

   localparam logic signed [IN_W-1:0] MIN_CODE = {1'b1, {(IN_W-1){1'b0}}};
   localparam logic [ACC_W-1:0]       MIN_MAG  = ACC_W'(env_follow_pkg::min_code_mag(IN_W));
   localparam logic [ACC_W-1:0]       NO_LEAK  = ACC_W'(1) << SHIFT;

   always_ff @(posedge clk) begin
      if (rst)       state_q <= '0;
      else if (load) state_q <= nxt;
   end

   a_r1_reset_clear: assert property (@(posedge clk) rst |=> state_q == '0);

   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(state_q));

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
      load |-> !nxt_carry);

   a_r7_zero_decay: assert property (@(posedge clk) disable iff (rst)
      (load && sample == '0) |=> state_q <= $past(state_q));

   a_r4_min_code: assert property (@(posedge clk) disable iff (rst)
      (load && sample == MIN_CODE && state_q < NO_LEAK) |=> state_q == $past(state_q) + MIN_MAG);

endmodule

// File: rtl/env_follower.sv
module env_follower #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned SHIFT = 6
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   smp_vld,
   input  logic signed [IN_W-1:0] smp_in,
   output logic [IN_W-1:0]        env_out
);

   localparam int unsigned ACC_W = env_follow_pkg::acc_width(IN_W, SHIFT);

   generate
      if (IN_W < 2) begin : g_bad_w
         $error("env_follower: IN_W must be at least 2");
      end
      if (SHIFT < 1 || SHIFT > 24) begin : g_bad_shift
         $error("env_follower: SHIFT must lie in 1..24");
      end
   endgenerate

   logic [ACC_W-1:0] state_q;
   logic [ACC_W-1:0] leaked;
   logic [ACC_W-1:0] nxt;
   logic             carry;

   env_leak #(.ACC_W(ACC_W), .SHIFT(SHIFT)) i_leak (
      .state_q (state_q),
      .leaked  (leaked)
   );

   env_rect_accum #(.IN_W(IN_W), .ACC_W(ACC_W)) i_accum (
      .base   (leaked),
      .sample (smp_in),
      .sum    (nxt),
      .carry  (carry)
   );

   env_state_reg #(.IN_W(IN_W), .SHIFT(SHIFT), .ACC_W(ACC_W)) i_state (
      .clk       (clk),
      .rst       (rst),
      .load      (smp_vld),
      .nxt       (nxt),
      .nxt_carry (carry),
      .sample    (smp_in),
      .state_q   (state_q)
   );

   assign env_out = state_q[ACC_W-1:SHIFT];

   a_r6_out_range: assert property (@(posedge clk) disable iff (rst)
      env_out <= IN_W'(env_follow_pkg::min_code_mag(IN_W)));

endmodule

// File: tb/test_env_follower.sv
module test_env_follower;

   localparam int IN_W  = 16;
   localparam int SHIFT = 6;

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic                   smp_vld = 1'b0;
   logic signed [IN_W-1:0] smp_in = '0;
   logic [IN_W-1:0]        env_out;

   int total = 0;
   int bad   = 0;

   typedef struct {
      longint exp;
      string  tag;
   } item_t;

   item_t  sb[$];
   longint model = 0;

   always #2.5 clk = ~clk;

   env_follower #(.IN_W(IN_W), .SHIFT(SHIFT)) i_env_follower (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in), .env_out(env_out)
   );

   task automatic check(input longint act, input longint exp, input string tag);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Monitor: compares one queued expectation one step after each edge.
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check(longint'(env_out), it.exp, it.tag);
      end
   end

   // Driver: applies one cycle of stimulus and pushes the expected result.
   task automatic drive(input bit vld, input int x, input string tag);
      item_t it;
      @(negedge clk);
      smp_vld = vld;
      smp_in  = IN_W'(x);
      if (vld) model = model - (model >>> SHIFT) + ((x < 0) ? -x : x);
      it.exp = model >>> SHIFT;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; smp_vld = 1'b0;
      sb.delete();
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model = 0;
      #0.5;
      check(longint'(env_out), 0, "R1 reset");
   endtask

   initial begin
      fork
         begin
            longint prev_env;
            longint pos_env;
            do_reset();

            // R3: small values, mixed sign, leak below threshold
            drive(1, 100, "R3 add positive");
            drive(1, -200, "R3 subtract negative");
            for (int i = 0; i < 80; i++) drive(1, (i % 2) ? 1000 : -1000, "R3 alternating");

            // R2: ignored samples
            for (int i = 0; i < 10; i++) drive(0, 30000 - i * 7000, "R2 hold");

            // R7: decay on zeros
            for (int i = 0; i < 150; i++) drive(1, 0, "R7 decay");

            // R4: most negative code from zero
            do_reset();
            drive(1, -32768, "R4 min code");
            drive(1, -32768, "R4 min code");

            // R5/R8: hold max magnitude until settled
            for (int i = 0; i < 1500; i++) drive(1, -32768, "R5 max magnitude");
            repeat (3) @(negedge clk);
            check(longint'(env_out), 32768, "R8 settle at max");
            check(longint'(env_out), 32768, "R5 no overflow");

            // R8: sign symmetry
            do_reset();
            for (int i = 0; i < 600; i++) drive(1, 5000, "R8 positive run");
            repeat (3) @(negedge clk);
            pos_env = longint'(env_out);
            check(pos_env, 5000, "R8 settle positive");
            do_reset();
            for (int i = 0; i < 600; i++) drive(1, -5000, "R8 negative run");
            repeat (3) @(negedge clk);
            check(longint'(env_out), pos_env, "R8 sign symmetry");

            // R6: modulated carrier, amplitude step, strobe gaps
            do_reset();
            for (int i = 0; i < 2000; i++) begin
               int amp;
               int ph;
               amp = (i < 1000) ? 4000 : 20000;
               ph  = i % 8;
               drive((i % 5) != 3, (ph < 4) ? amp : -amp, "R6 carrier");
            end
            repeat (3) @(negedge clk);
            prev_env = longint'(env_out);
            check(longint'(prev_env > 15000), 1, "R6 envelope follows step");
         end
         begin
            repeat (100000) @(posedge clk);
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule